// File: doc/BRIEF.md
# I2C Serial Clock Generator with Multi-Master Synchronization

This block produces the serial clock of an I2C master on an open-drain line. It counts a programmable low period and a programmable high period in system clock cycles. It drives the line low for the low period and then releases it. The high count starts only once the line has actually been seen high, so a slave that holds the clock low stretches the transfer. The transfer stays suspended until the line is released.

When another master pulls the clock low during the high period, the high period ends at once. A fresh low period is then counted from that falling edge. When several masters clock the line together, the wired-AND bus therefore takes the high time of the master with the shortest high time. It takes the low time of the master with the longest low time. The timing of this master changes only through stretching or through another master.

A byte engine uses the drive-low enable and three one-cycle phase strobes: rising, falling and mid-high. Both counts are run-time inputs, so one instance serves standard and fast bus rates.

Top module: `scl_clock_gen`

## Requirements
- R1: After reset, and while `enable` stays low from reset onward, `sclDriveLow`, `riseStrobe`, `fallStrobe` and `midHighStrobe` are all 0.
- R2: Each low phase holds `sclDriveLow` at 1 for exactly `lowCount` consecutive cycles (`lowCount` >= 2). `fallStrobe` is 1 in the first of those cycles.
- R3: After the line is released, `riseStrobe` is never raised while `sclIn` is low. Once `sclIn` goes high and stays high, `riseStrobe` is 1 in the third cycle, which covers a two-flop synchronizer plus one state register.
- R4: If `sclIn` stays high, `fallStrobe` and `sclDriveLow` rise exactly `highCount` cycles after `riseStrobe` (`highCount` >= 2).
- R5: If `sclIn` goes low during the high phase, the high phase is abandoned. `fallStrobe` and `sclDriveLow` become 1 in the third cycle after the line falls.
- R6: The low phase that follows an abandoned high phase lasts the full `lowCount` cycles, counted from its own start.
- R7: `midHighStrobe` pulses once, ceil(`highCount`/2) cycles after `riseStrobe`. It does not pulse if the high phase was abandoned before that point.
- R8: `lowCount` and `highCount` are read each time a phase starts, so new values take effect on the next phase without a reset.
- R9: When `enable` goes low, the current period completes and the block then leaves the line released. It produces no further `fallStrobe` and keeps `sclDriveLow` at 0.
- R10: At most one of the three strobes is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the clock; when low, the block stops after the current period |
| lowCount | input | CNT_W | Low period in clock cycles |
| highCount | input | CNT_W | High period in clock cycles |
| sclIn | input | 1 | Sampled level of the shared clock line |
| sclDriveLow | output | 1 | 1 = pull the clock line low |
| riseStrobe | output | 1 | One-cycle pulse when the high phase starts |
| fallStrobe | output | 1 | One-cycle pulse when a low phase starts |
| midHighStrobe | output | 1 | One-cycle pulse at the middle of the high phase |

## Verification
The bench models the wired-AND line by combining the design's drive with a second device that pulls low. In one period that device cuts the high phase short and then holds the line low past the design's own low count, which acts as a longer low time. A design that kept counting high after the line fell would show a long high phase instead of the short one. A design that counted its low time from its own release would drive a low phase that is too short. A design that timed the high phase from its own release, and not from the line level, would pulse `riseStrobe` during the stretch. Running with two count settings catches counts that are latched only once, and a final period with `enable` dropped catches an extra falling edge after the stop.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_WAIT = 2'd2,
    ST_HIGH = 2'd3
  } sclState_t;

  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic dec;
  } cntCtl_t;

endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  output logic sclSync
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) chain[0] <= 1'b1;
          else       chain[0] <= sclIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) chain[i] <= 1'b1;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign sclSync = chain[STAGES-1];

endmodule

// File: rtl/scl_count.sv
module scl_count
  import scl_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCtl_t          ctl,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  output logic             cntZero,
  output logic             cntMid
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)             cnt <= '0;
    else if (ctl.loadLow)  cnt <= lowCount - ONE;
    else if (ctl.loadHigh) cnt <= highCount - ONE;
    else if (ctl.dec)      cnt <= cnt - ONE;
  end

  assign cntZero = (cnt == '0);
  assign cntMid  = (cnt == (highCount >> 1));

  // the control must never ask for a decrement once the count is spent
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dec |-> cnt != '0);

endmodule

// File: rtl/scl_ctrl.sv
module scl_ctrl
  import scl_gen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    sclSync,
  input  logic    cntZero,
  input  logic    cntMid,
  output cntCtl_t ctl,
  output logic    sclDriveLow,
  output logic    riseStrobe,
  output logic    fallStrobe,
  output logic    midHighStrobe
);

  sclState_t state, stateNxt;
  logic riseNxt, fallNxt, midNxt;

  always_comb begin
    stateNxt     = state;
    ctl          = '0;
    riseNxt      = 1'b0;
    fallNxt      = 1'b0;
    midNxt       = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (enable) begin
          stateNxt    = ST_LOW;
          ctl.loadLow = 1'b1;
          fallNxt     = 1'b1;
        end
      end
      ST_LOW: begin
        if (cntZero) stateNxt = ST_WAIT;
        else         ctl.dec  = 1'b1;
      end
      ST_WAIT: begin
        if (sclSync) begin
          stateNxt     = ST_HIGH;
          ctl.loadHigh = 1'b1;
          riseNxt      = 1'b1;
        end
      end
      ST_HIGH: begin
        if (!sclSync) begin
          stateNxt    = ST_LOW;
          ctl.loadLow = 1'b1;
          fallNxt     = 1'b1;
        end else if (cntZero) begin
          if (enable) begin
            stateNxt    = ST_LOW;
            ctl.loadLow = 1'b1;
            fallNxt     = 1'b1;
          end else begin
            stateNxt = ST_IDLE;
          end
        end else begin
          ctl.dec = 1'b1;
          midNxt  = cntMid;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      riseStrobe    <= 1'b0;
      fallStrobe    <= 1'b0;
      midHighStrobe <= 1'b0;
    end else begin
      state         <= stateNxt;
      riseStrobe    <= riseNxt;
      fallStrobe    <= fallNxt;
      midHighStrobe <= midNxt;
    end
  end

  assign sclDriveLow = (state == ST_LOW);

  p_rise_after_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    riseStrobe |-> $past(sclSync) && !sclDriveLow);

  p_fall_drives_r2: assert property (@(posedge clk) disable iff (!rstN)
    fallStrobe |-> sclDriveLow);

  p_abort_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HIGH && !sclSync) |=> fallStrobe && sclDriveLow);

  p_mid_released_r7: assert property (@(posedge clk) disable iff (!rstN)
    midHighStrobe |-> !sclDriveLow && $past(sclSync));

  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({riseStrobe, fallStrobe, midHighStrobe}));

endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import scl_gen_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CNT_W-1:0] lowCount,
  input  logic [CNT_W-1:0] highCount,
  input  logic             sclIn,
  output logic             sclDriveLow,
  output logic             riseStrobe,
  output logic             fallStrobe,
  output logic             midHighStrobe
);

  logic    sclSync;
  logic    cntZero;
  logic    cntMid;
  cntCtl_t ctl;

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sclSync (sclSync)
  );

  scl_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .enable        (enable),
    .sclSync       (sclSync),
    .cntZero       (cntZero),
    .cntMid        (cntMid),
    .ctl           (ctl),
    .sclDriveLow   (sclDriveLow),
    .riseStrobe    (riseStrobe),
    .fallStrobe    (fallStrobe),
    .midHighStrobe (midHighStrobe)
  );

  scl_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .lowCount  (lowCount),
    .highCount (highCount),
    .cntZero   (cntZero),
    .cntMid    (cntMid)
  );

endmodule

// File: tb/scl_clock_gen_bench.sv
module scl_clock_gen_bench;

  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic otherLow = 1'b0;
  logic [CNT_W-1:0] lowCount = 16'd6;
  logic [CNT_W-1:0] highCount = 16'd5;
  logic sclDriveLow, riseStrobe, fallStrobe, midHighStrobe;
  logic sclIn;

  assign sclIn = !(sclDriveLow || otherLow);

  always #4 clk = ~clk;

  scl_clock_gen #(.CNT_W(CNT_W)) u_scl_clock_gen (
    .clk           (clk),
    .rstN          (rstN),
    .enable        (enable),
    .lowCount      (lowCount),
    .highCount     (highCount),
    .sclIn         (sclIn),
    .sclDriveLow   (sclDriveLow),
    .riseStrobe    (riseStrobe),
    .fallStrobe    (fallStrobe),
    .midHighStrobe (midHighStrobe)
  );

  int total = 0;
  int bad = 0;
  int lowQ[$];
  int highQ[$];
  int lowRun = 0;
  int highCnt = 0;
  bit highOpen = 1'b0;
  int hcCur = 5;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures phases and pops expected lengths
  always @(negedge clk) begin
    int s;
    int e;
    if (rstN) begin
      s = int'(riseStrobe) + int'(fallStrobe) + int'(midHighStrobe);
      if (s > 1) check(1'b0, "R10 strobes", s, 1);
      if (highOpen) highCnt++;
      if (sclDriveLow) lowRun++;
      else if (lowRun > 0) begin
        if (lowQ.size() > 0) begin
          e = lowQ.pop_front();
          check(lowRun == e, "R2 R6 low length", lowRun, e);
        end else check(1'b0, "R2 unexpected low", lowRun, 0);
        lowRun = 0;
      end
      if (fallStrobe) begin
        check(sclDriveLow, "R2 fall with drive", int'(sclDriveLow), 1);
        if (highOpen) begin
          if (highQ.size() > 0) begin
            e = highQ.pop_front();
            check(highCnt == e, "R4 R5 high length", highCnt, e);
          end else check(1'b0, "R4 unexpected high", highCnt, 0);
          highOpen = 1'b0;
        end
      end
      if (midHighStrobe)
        check(highOpen && highCnt == (hcCur + 1) / 2, "R7 mid position", highCnt, (hcCur + 1) / 2);
      if (riseStrobe) begin
        highOpen = 1'b1;
        highCnt = 0;
      end
    end
  end

  task automatic waitRises(input int n);
    int seen = 0;
    while (seen < n) begin
      @(negedge clk);
      if (riseStrobe) seen++;
    end
  endtask

  // R9: after enable drops in a high phase, no new low phase appears
  task automatic stopAndSettle();
    int badCnt = 0;
    enable = 1'b0;
    for (int i = 0; i < int'(highCount) + 30; i++) begin
      @(negedge clk);
      if (sclDriveLow || fallStrobe || riseStrobe) badCnt++;
    end
    check(badCnt == 0, "R9 parked released", badCnt, 0);
    @(posedge clk);
    highOpen = 1'b0;
  endtask

  task automatic runPeriods(input int lc, input int hc, input int k);
    lowCount = CNT_W'(lc);
    highCount = CNT_W'(hc);
    hcCur = hc;
    for (int i = 0; i < k; i++) lowQ.push_back(lc);
    for (int i = 0; i < k - 1; i++) highQ.push_back(hc);
    enable = 1'b1;
    waitRises(k);
    stopAndSettle();
  endtask

  initial begin
    int n;
    int badCnt;
    repeat (3) @(negedge clk);
    check(!sclDriveLow && !riseStrobe && !fallStrobe && !midHighStrobe, "R1 in reset",
          int'({sclDriveLow, riseStrobe, fallStrobe, midHighStrobe}), 0);
    rstN = 1'b1;
    badCnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sclDriveLow || riseStrobe || fallStrobe || midHighStrobe) badCnt++;
    end
    check(badCnt == 0, "R1 idle after reset", badCnt, 0);

    // R4 R7 basic periods, then R8 new counts without reset
    runPeriods(6, 5, 3);
    runPeriods(9, 8, 3);

    // R5 R6 R3: another master shortens the high phase and stretches the low
    lowCount = 16'd10;
    highCount = 16'd12;
    hcCur = 12;
    for (int i = 0; i < 4; i++) lowQ.push_back(10);
    highQ.push_back(12);
    highQ.push_back(5);
    highQ.push_back(12);
    enable = 1'b1;
    waitRises(2);
    repeat (2) @(negedge clk);
    otherLow = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fallStrobe && n < 50);
    check(n == 3, "R5 abort latency", n, 3);
    check(sclDriveLow, "R5 drive after abort", int'(sclDriveLow), 1);
    while (sclDriveLow) @(negedge clk);
    badCnt = 0;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      if (riseStrobe) badCnt++;
    end
    check(badCnt == 0, "R3 no rise while stretched", badCnt, 0);
    otherLow = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!riseStrobe && n < 50);
    check(n == 3, "R3 rise latency", n, 3);
    waitRises(1);
    stopAndSettle();

    check(lowQ.size() == 0 && highQ.size() == 0, "R2 R4 all phases seen",
          lowQ.size() + highQ.size(), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      check(1'b0, "R1 watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule